// File: doc/BRIEF.md
# Stepper Micro-Step Position Translator

This block turns a stream of step strobes into a pair of signed current setpoints for the two coils of a two-phase stepper motor. It holds a 9-bit electrical angle that covers one full electrical revolution in 512 counts. Each rising edge of the step strobe moves that angle up or down by a distance that depends on the chosen step resolution. The angle is then mapped to a percentage of full-scale current for each coil. A downstream current regulator uses these setpoints as its targets.

In most modes the two setpoints follow a sine and a cosine, so the (X, Y) pair traces a circle. Two uncompensated modes drive every non-zero coil at the full 100 %, so the pair traces a square. When the resolution changes, the angle is moved onto the grid of the new mode. The uncompensated full-step mode only allows the four diagonal angles. In that mode the angle moves to the next diagonal in the direction of travel.

Top module: `stepTranslator`

## Requirements
- R1: After reset the angle is 0, coil X is 0, coil Y is +100 and the resolution is 1/32 step.
- R2: The angle moves only on a 0-to-1 transition of the step strobe, as sampled on the clock. A strobe held high gives exactly one move.
- R3: Travel is upward (angle increases) when the direction pin XOR the direction-invert bit is 1, and downward when it is 0.
- R4: The angle wraps modulo 512 in both directions.
- R5: Step sizes are selected as follows. A main field of 000/001/010/011 gives 4/8/16/32 counts. 100 gives 64 counts (compensated half step). 111 gives 128 counts (compensated full step). When the extension field is 001 it overrides the main field with 1 count (1/128). When it is 010 it overrides with 2 counts (1/64). Any other extension value leaves the main field in control.
- R6: In the circular modes, coil X is round(100·sin(2π·angle/512)) and coil Y is round(100·cos(2π·angle/512)), each within ±1.
- R7: Main field 101 selects uncompensated half step (64 counts). Coil X is +100 for angles 1..255, −100 for 257..511 and 0 at 0 and 256. Coil Y follows the same rule applied to angle+128.
- R8: Main field 110 selects uncompensated full step (128 counts). The angle is always an odd multiple of 64, and both coils are ±100 by the R7 rule.
- R9: When the decoded mode changes, the angle is first rounded down to a multiple of the new step size (all modes except uncompensated full step).
- R10: On entry to uncompensated full step, an angle that is already an odd multiple of 64 is kept. Otherwise the angle moves to the nearest odd multiple of 64 that lies strictly ahead in the current direction of travel.
- R11: If a mode change and a step edge arrive in the same cycle, the snap is applied first. The new mode's step is then added to the snapped angle.
- R12: The angle and both setpoints are registered. They change on the same clock edge that samples the step edge or the mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stepIn | input | 1 | Step strobe; each rising edge is one step |
| dirIn | input | 1 | Direction pin |
| dirInvert | input | 1 | Direction-invert control bit |
| stdMode | input | 3 | Main step-mode field |
| extMode | input | 3 | Extension step-mode field |
| pos | output | 9 | Electrical angle |
| coilX | output | 8 | Signed coil X setpoint, percent of full scale |
| coilY | output | 8 | Signed coil Y setpoint, percent of full scale |

## Verification
The two functions that can coincide are the grid snap caused by a mode change and the move caused by a step edge. Their order decides the final angle. The bench changes the mode fields and raises the strobe at the same negative edge. It does this both for an ordinary resolution switch and for entry into uncompensated full step while travelling downward. It then compares the angle and setpoints against a behavioural model that snaps first and steps second. The same model also checks every cycle of full-revolution sweeps, held strobes, inverted direction and wrap-around.

// File: rtl/stepTransPkg.sv
package stepTransPkg;

  typedef enum logic [3:0] {
    MODE_M128,
    MODE_M64,
    MODE_M32,
    MODE_M16,
    MODE_M8,
    MODE_M4,
    MODE_HALF,
    MODE_FULL,
    MODE_SQ_HALF,
    MODE_SQ_FULL
  } stepMode_e;

  typedef struct packed {
    logic      stepGo;
    logic      snapGo;
    logic      fwd;
    stepMode_e mode;
  } ctlStrobe_t;

  // log2 of the step distance, relative to the finest (1/128) resolution
  function automatic logic [2:0] modeShift(stepMode_e m);
    case (m)
      MODE_M128:    return 3'd0;
      MODE_M64:     return 3'd1;
      MODE_M32:     return 3'd2;
      MODE_M16:     return 3'd3;
      MODE_M8:      return 3'd4;
      MODE_M4:      return 3'd5;
      MODE_HALF,
      MODE_SQ_HALF: return 3'd6;
      MODE_FULL,
      MODE_SQ_FULL: return 3'd7;
      default:      return 3'd2;
    endcase
  endfunction

  function automatic logic modeSquare(stepMode_e m);
    return (m == MODE_SQ_HALF) || (m == MODE_SQ_FULL);
  endfunction

  // Rational sine approximation over a half wave of halfWave counts,
  // scaled to 'scale' and rounded to nearest.
  function automatic int sineMag(int idx, int halfWave, int scale);
    longint u;
    longint h;
    longint num;
    longint den;
    u   = longint'(idx);
    h   = longint'(halfWave);
    num = 16 * u * (h - u);
    den = 5 * h * h - 4 * u * (h - u);
    return int'((2 * longint'(scale) * num + den) / (2 * den));
  endfunction

endpackage

// File: rtl/stepCtrl.sv
module stepCtrl
  import stepTransPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepIn,
  input  logic       dirIn,
  input  logic       dirInvert,
  input  logic [2:0] stdMode,
  input  logic [2:0] extMode,
  output ctlStrobe_t ctl
);

  logic      stepQ;
  stepMode_e modeQ;
  stepMode_e modeNow;

  always_comb begin
    case (extMode)
      3'd1:    modeNow = MODE_M128;
      3'd2:    modeNow = MODE_M64;
      default: begin
        case (stdMode)
          3'd0:    modeNow = MODE_M32;
          3'd1:    modeNow = MODE_M16;
          3'd2:    modeNow = MODE_M8;
          3'd3:    modeNow = MODE_M4;
          3'd4:    modeNow = MODE_HALF;
          3'd5:    modeNow = MODE_SQ_HALF;
          3'd6:    modeNow = MODE_SQ_FULL;
          default: modeNow = MODE_FULL;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ <= 1'b0;
      modeQ <= MODE_M32;
    end else begin
      stepQ <= stepIn;
      modeQ <= modeNow;
    end
  end

  always_comb begin
    ctl.stepGo = stepIn & ~stepQ;
    ctl.snapGo = (modeNow != modeQ);
    ctl.fwd    = dirIn ^ dirInvert;
    ctl.mode   = modeNow;
  end

  // R2: a held strobe never yields two consecutive step requests
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepGo |=> !ctl.stepGo);

  // R2: a step request needs the strobe high now
  a_r2_edge_needs_high: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepGo |-> stepIn);

endmodule

// File: rtl/stepWaveLut.sv
module stepWaveLut
  import stepTransPkg::*;
#(
  parameter int POS_W      = 9,
  parameter int PCT_W      = 8,
  parameter int FULL_SCALE = 100
) (
  input  logic [POS_W-1:0]        phase,
  input  logic                    square,
  output logic signed [PCT_W-1:0] pct
);

  localparam int QTR   = 1 << (POS_W - 2);
  localparam int HALF  = 2 * QTR;
  localparam int MAG_W = $clog2(FULL_SCALE + 1);

  logic [MAG_W-1:0] magTab [0:QTR];

  for (genvar g = 0; g <= QTR; g++) begin : gTab
    assign magTab[g] = MAG_W'(sineMag(g, HALF, FULL_SCALE));
  end

  logic [POS_W-1:0] inHalf;
  logic [POS_W-1:0] idx;
  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] level;
  logic signed [PCT_W-1:0] levelS;

  always_comb begin
    inHalf = {1'b0, phase[POS_W-2:0]};
    idx    = (inHalf <= POS_W'(QTR)) ? inHalf : (POS_W'(HALF) - inHalf);
    mag    = magTab[idx];
    if (square) level = (mag == '0) ? '0 : MAG_W'(FULL_SCALE);
    else        level = mag;
    levelS = $signed({{(PCT_W - MAG_W){1'b0}}, level});
    pct    = phase[POS_W-1] ? -levelS : levelS;
  end

endmodule

// File: rtl/stepPath.sv
module stepPath
  import stepTransPkg::*;
#(
  parameter int POS_W      = 9,
  parameter int PCT_W      = 8,
  parameter int FULL_SCALE = 100
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              ctl,
  output logic [POS_W-1:0]        posQ,
  output logic signed [PCT_W-1:0] coilXQ,
  output logic signed [PCT_W-1:0] coilYQ
);

  localparam int SHIFT_OFS = POS_W - 9;
  localparam int QTR       = 1 << (POS_W - 2);
  localparam int ODD_UNIT  = 1 << (POS_W - 3);
  localparam int FULL_UNIT = 2 * ODD_UNIT;
  localparam int NCOIL     = 2;

  logic [POS_W-1:0] stepSize;
  logic [POS_W-1:0] snapped;
  logic [POS_W-1:0] fwdSnap;
  logic [POS_W-1:0] bwdSnap;
  logic [POS_W-1:0] baseSnap;
  logic [POS_W-1:0] posNext;
  logic             onDiag;
  logic             square;

  always_comb begin
    stepSize = POS_W'(1) << (int'(modeShift(ctl.mode)) + SHIFT_OFS);
    square   = modeSquare(ctl.mode);
    onDiag   = (posQ & POS_W'(FULL_UNIT - 1)) == POS_W'(ODD_UNIT);
    fwdSnap  = ((posQ - POS_W'(ODD_UNIT)) | POS_W'(FULL_UNIT - 1))
               + POS_W'(1) + POS_W'(ODD_UNIT);
    bwdSnap  = ((posQ - POS_W'(ODD_UNIT)) & ~POS_W'(FULL_UNIT - 1))
               + POS_W'(ODD_UNIT);
    if (ctl.mode == MODE_SQ_FULL)
      snapped = onDiag ? posQ : (ctl.fwd ? fwdSnap : bwdSnap);
    else
      snapped = posQ & ~(stepSize - POS_W'(1));
    baseSnap = ctl.snapGo ? snapped : posQ;
    if (ctl.stepGo)
      posNext = ctl.fwd ? (baseSnap + stepSize) : (baseSnap - stepSize);
    else
      posNext = baseSnap;
  end

  logic signed [PCT_W-1:0] coilPct [NCOIL];

  // coil 0 takes the sine of the angle, coil 1 the cosine (quarter turn ahead)
  for (genvar c = 0; c < NCOIL; c++) begin : gCoil
    logic [POS_W-1:0] phase;
    assign phase = posNext + POS_W'(c * QTR);
    stepWaveLut #(
      .POS_W      (POS_W),
      .PCT_W      (PCT_W),
      .FULL_SCALE (FULL_SCALE)
    ) u_lut (
      .phase  (phase),
      .square (square),
      .pct    (coilPct[c])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ   <= '0;
      coilXQ <= '0;
      coilYQ <= PCT_W'(FULL_SCALE);
    end else begin
      posQ   <= posNext;
      coilXQ <= coilPct[0];
      coilYQ <= coilPct[1];
    end
  end

  // R2: with no step and no snap the angle holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.stepGo && !ctl.snapGo) |=> $stable(posQ));

  // R5: a plain step moves by exactly the selected distance
  a_r5_step_distance: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepGo && !ctl.snapGo) |=>
      ((posQ == $past(posQ) + $past(stepSize)) ||
       (posQ == $past(posQ) - $past(stepSize))));

  // R8: uncompensated full step keeps the angle on a diagonal
  a_r8_diag_only: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == MODE_SQ_FULL) |=>
      ((posQ & POS_W'(FULL_UNIT - 1)) == POS_W'(ODD_UNIT)));

  // R9: every other mode keeps the angle on its own grid
  a_r9_on_grid: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode != MODE_SQ_FULL) |=>
      ((posQ & ($past(stepSize) - POS_W'(1))) == '0));

  // R7: square modes only produce 0 or full scale magnitudes
  a_r7_square_levels: assert property (@(posedge clk) disable iff (!rstN)
    square |=>
      ((coilXQ == 0 || coilXQ == PCT_W'(FULL_SCALE) || coilXQ == -PCT_W'(FULL_SCALE)) &&
       (coilYQ == 0 || coilYQ == PCT_W'(FULL_SCALE) || coilYQ == -PCT_W'(FULL_SCALE))));

  // R6: circular modes stay near the unit circle
  a_r6_radius: assert property (@(posedge clk) disable iff (!rstN)
    !square |=>
      ((int'(coilXQ) * int'(coilXQ) + int'(coilYQ) * int'(coilYQ)) >= (FULL_SCALE * FULL_SCALE * 97) / 100 &&
       (int'(coilXQ) * int'(coilXQ) + int'(coilYQ) * int'(coilYQ)) <= (FULL_SCALE * FULL_SCALE * 103) / 100));

endmodule

// File: rtl/stepTranslator.sv
module stepTranslator
  import stepTransPkg::*;
#(
  parameter int POS_W      = 9,
  parameter int PCT_W      = 8,
  parameter int FULL_SCALE = 100
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stepIn,
  input  logic                    dirIn,
  input  logic                    dirInvert,
  input  logic [2:0]              stdMode,
  input  logic [2:0]              extMode,
  output logic [POS_W-1:0]        pos,
  output logic signed [PCT_W-1:0] coilX,
  output logic signed [PCT_W-1:0] coilY
);

  ctlStrobe_t ctl;

  stepCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stepIn    (stepIn),
    .dirIn     (dirIn),
    .dirInvert (dirInvert),
    .stdMode   (stdMode),
    .extMode   (extMode),
    .ctl       (ctl)
  );

  stepPath #(
    .POS_W      (POS_W),
    .PCT_W      (PCT_W),
    .FULL_SCALE (FULL_SCALE)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .posQ   (pos),
    .coilXQ (coilX),
    .coilYQ (coilY)
  );

endmodule

// File: tb/stepTranslator_bench.sv
`timescale 1ns/1ps
module stepTranslator_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN;
  logic              stepIn;
  logic              dirIn;
  logic              dirInvert;
  logic [2:0]        stdMode;
  logic [2:0]        extMode;
  logic [8:0]        pos;
  logic signed [7:0] coilX;
  logic signed [7:0] coilY;

  stepTranslator u_stepTranslator (
    .clk(clk), .rstN(rstN), .stepIn(stepIn), .dirIn(dirIn),
    .dirInvert(dirInvert), .stdMode(stdMode), .extMode(extMode),
    .pos(pos), .coilX(coilX), .coilY(coilY)
  );

  int checks = 0;
  int fails  = 0;

  // reference state
  int refPos   = 0;
  int refId    = 0;
  int refKind  = 0;   // 0 circle, 1 square half, 2 square full
  bit refPrev  = 0;

  task automatic decodeRef(input logic [2:0] s, input logic [2:0] e,
                           output int size, output int kind, output int id);
    kind = 0;
    if (e == 3'd1)      begin size = 1; id = 100; end
    else if (e == 3'd2) begin size = 2; id = 101; end
    else begin
      id = int'(s);
      case (s)
        3'd0: size = 4;
        3'd1: size = 8;
        3'd2: size = 16;
        3'd3: size = 32;
        3'd4: size = 64;
        3'd5: begin size = 64;  kind = 1; end
        3'd6: begin size = 128; kind = 2; end
        default: size = 128;
      endcase
    end
  endtask

  task automatic modelUpdate();
    int size, kind, id;
    bit up;
    decodeRef(stdMode, extMode, size, kind, id);
    up = dirIn ^ dirInvert;
    if (id != refId) begin
      if (kind == 2) begin
        if (refPos % 128 != 64) begin
          for (int d = 1; d <= 128; d++) begin
            int cand;
            cand = up ? (refPos + d) % 512 : (refPos - d + 512) % 512;
            if (cand % 128 == 64) begin refPos = cand; break; end
          end
        end
      end else begin
        refPos = refPos - (refPos % size);
      end
    end
    if (stepIn && !refPrev)
      refPos = up ? (refPos + size) % 512 : (refPos - size + 512) % 512;
    refId   = id;
    refKind = kind;
    refPrev = stepIn;
  endtask

  function automatic int sqLevel(int p);
    if (p > 0 && p < 256) return 100;
    if (p > 256)          return -100;
    return 0;
  endfunction

  function automatic int circLevel(int p);
    real r;
    r = 100.0 * $sin(2.0 * 3.14159265358979 * real'(p) / 512.0);
    return int'($floor(r + 0.5));
  endfunction

  task automatic compare(input string tag);
    int ex, ey, tol, dx, dy;
    if (refKind != 0) begin
      ex = sqLevel(refPos); ey = sqLevel((refPos + 128) % 512); tol = 0;
    end else begin
      ex = circLevel(refPos); ey = circLevel((refPos + 128) % 512); tol = 1;
    end
    checks++;
    if (int'(pos) != refPos) begin
      fails++;
      $display("FAIL %s pos actual %0d expected %0d", tag, pos, refPos);
    end
    checks++;
    dx = int'(coilX) - ex;
    if (dx > tol || dx < -tol) begin
      fails++;
      $display("FAIL %s coilX actual %0d expected %0d (pos %0d)", tag, coilX, ex, refPos);
    end
    checks++;
    dy = int'(coilY) - ey;
    if (dy > tol || dy < -tol) begin
      fails++;
      $display("FAIL %s coilY actual %0d expected %0d (pos %0d)", tag, coilY, ey, refPos);
    end
  endtask

  task automatic tick(input logic st, input string tag);
    stepIn = st;
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic stepN(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick(1'b1, tag);
      tick(1'b0, tag);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; stepIn = 1'b0; dirIn = 1'b1; dirInvert = 1'b0;
    stdMode = 3'd0; extMode = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rstN = 1'b1;
    tick(1'b0, "R1");

    // R6: 1/32 full revolution upward, then 1/128 revolution both ways
    stepN(128, "R6");
    extMode = 3'd1; stepN(512, "R6");
    dirIn = 1'b0;   stepN(512, "R6");
    dirIn = 1'b1; extMode = 3'd0;

    // R2: strobe held high for several cycles
    tick(1'b1, "R2"); tick(1'b1, "R2"); tick(1'b1, "R2"); tick(1'b1, "R2");
    tick(1'b0, "R2"); tick(1'b0, "R2");

    // R5: every resolution selection, extension override and fall-through
    for (int s = 0; s < 8; s++) begin
      if (s != 5 && s != 6) begin
        stdMode = 3'(s);
        stepN(10, "R5");
      end
    end
    extMode = 3'd1; stepN(20, "R5");
    extMode = 3'd2; stepN(20, "R5");
    extMode = 3'd3; stdMode = 3'd1; stepN(5, "R5");
    extMode = 3'd0; stdMode = 3'd0;

    // R3: direction pin XOR invert bit
    dirIn = 1'b1; dirInvert = 1'b1; stepN(20, "R3");
    dirIn = 1'b0; dirInvert = 1'b1; stepN(10, "R3");
    dirIn = 1'b0; dirInvert = 1'b0; stepN(10, "R3");

    // R4: wrap below zero and above 511
    stdMode = 3'd3; stepN(20, "R4");
    dirIn = 1'b1;   stepN(40, "R4");

    // R7: uncompensated half step both ways
    stdMode = 3'd5; stepN(16, "R7");
    dirIn = 1'b0;   stepN(16, "R7");
    dirIn = 1'b1;

    // R9: rounding down on a resolution switch
    extMode = 3'd1; stepN(37, "R9");
    extMode = 3'd0; stdMode = 3'd2; tick(1'b0, "R9");
    stepN(3, "R9");
    extMode = 3'd1; stepN(5, "R9");
    extMode = 3'd0; stdMode = 3'd4; tick(1'b0, "R9");

    // R10 / R8: entry to uncompensated full step and its revolution
    extMode = 3'd1; stepN(10, "R10");
    extMode = 3'd0; stdMode = 3'd6; tick(1'b0, "R10");
    stepN(8, "R8");
    dirIn = 1'b0; stepN(8, "R8");
    extMode = 3'd1; stepN(3, "R10");
    extMode = 3'd0; stdMode = 3'd6; tick(1'b0, "R10");
    stdMode = 3'd0; tick(1'b0, "R10");
    stdMode = 3'd6; tick(1'b0, "R10");

    // R11: snap and step in the same cycle
    dirIn = 1'b1; extMode = 3'd1; stepN(5, "R11");
    extMode = 3'd0; stdMode = 3'd3; tick(1'b1, "R11"); tick(1'b0, "R11");
    extMode = 3'd1; stepN(3, "R11");
    extMode = 3'd0; stdMode = 3'd6; dirIn = 1'b0;
    tick(1'b1, "R11"); tick(1'b0, "R11");

    // R12: outputs move on the sampling edge only
    stdMode = 3'd0; dirIn = 1'b1;
    tick(1'b0, "R12"); tick(1'b1, "R12"); tick(1'b1, "R12"); tick(1'b0, "R12");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule